// File: doc/BRIEF.md
# Block Framer with Sync Sequence-Number Restore

This block rebuilds packet framing on a stream of valid samples that comes back from a path which has kept the data but dropped the markers, such as an external-memory reorder stage. It counts valid samples and sets start-of-packet on the first sample and end-of-packet on the last sample of every block of `BLK_LEN` samples. On the first block of each group of `BLKS_PER_SYNC` blocks it also raises a sync marker together with start-of-packet. The returning data and valid strobe go through one register stage, so that they line up with the registered markers.

The memory path has an unknown latency. The block sequence number (BSN) seen at each input sync therefore travels beside it in a small queue built from logic. The queue is written on every input sync and read on every output sync. Its output is show-ahead, so the oldest entry is on the output BSN field in the same cycle as the output sync that removes it. If no entry is waiting when an output sync occurs, the last value read is repeated and a sticky underflow flag is set.

Top module: `stream_reframer`

## Requirements
- R1: `out_valid` and `out_data` equal `ret_valid` and `ret_data` of the previous clock cycle.
- R2: `out_sop` is high with the 1st, (BLK_LEN+1)th, (2·BLK_LEN+1)th, … valid output sample. Only cycles with `ret_valid` high advance the count.
- R3: `out_eop` is high with every BLK_LEN-th valid output sample, and only on valid cycles.
- R4: `out_sync` is high exactly on the start-of-packet of block 0, BLKS_PER_SYNC, 2·BLKS_PER_SYNC, … counted since reset.
- R5: Every cycle with `in_sync` high stores `in_bsn` at the tail of a FIFO_DEPTH-entry (default 16) queue. A store while the queue is full is dropped, unless an entry is removed in the same cycle.
- R6: In a cycle with `out_sync` high and the queue not empty, `out_bsn` shows the oldest stored value in that same cycle, and that value is removed at the clock edge.
- R7: `out_bsn` is zero in every cycle where `out_sync` is low.
- R8: In a cycle with `out_sync` high and the queue empty, `out_bsn` repeats the last value removed (zero if none since reset). From the next cycle `bsn_underflow` is high and stays high until reset.
- R9: With `rst_n` low at a clock edge, all outputs go to zero, both counters restart at zero and the queue empties.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_sync | input | 1 | Input sync marker; stores `in_bsn` |
| in_bsn | input | BSN_W | Input block sequence number |
| ret_valid | input | 1 | Valid strobe of the returning data |
| ret_data | input | DATA_W | Returning data |
| out_valid | output | 1 | Output valid |
| out_data | output | DATA_W | Output data |
| out_sop | output | 1 | Start of block |
| out_eop | output | 1 | End of block |
| out_sync | output | 1 | Sync on the first block of a group |
| out_bsn | output | BSN_W | Restored sequence number on sync cycles, zero otherwise |
| bsn_underflow | output | 1 | Sticky: an output sync found the queue empty |

## Verification
The stimulus uses gapped valid strobes, where a counter that also advanced on idle cycles would put start-of-packet and sync on the wrong samples. It also drives a run of stores and removals in the same cycle: a queue with an off-by-one in its show-ahead path would put the previous or the next sequence number on the sync. A long burst of input syncs with no output overfills the queue, and a design that wrapped its write pointer would overwrite older entries, which then come out out of order. A long stretch of output syncs with no input syncs empties the queue, and a design that read stale storage or cleared the field would show a wrong value in place of the repeated one, or fail to raise the sticky flag.

// File: rtl/reframer_pkg.sv
// Package: shared types and helper for the stream reframer.
// Assumes: nothing beyond IEEE 1800-2017.
package reframer_pkg;

    // Marker set produced by the framing counters, registered as one unit
    typedef struct packed {
        logic valid;
        logic sop;
        logic eop;
        logic sync;
    } frame_marks_t;

    // Counter width that is at least one bit for a modulus of one
    function automatic int cnt_width(input int modulus);
        return (modulus > 1) ? $clog2(modulus) : 1;
    endfunction

endpackage

// File: rtl/frame_counter.sv
// Module: frame_counter
// Counts valid samples into blocks of BLK_LEN, and blocks into groups of
// BLKS_PER_SYNC. Emits registered sop/eop/sync markers together with a
// registered copy of the valid strobe, so all are one cycle after the input.
// Assumes: BLK_LEN >= 1, BLKS_PER_SYNC >= 1, no backpressure.
module frame_counter
    import reframer_pkg::*;
#(
    parameter int BLK_LEN       = 8,
    parameter int BLKS_PER_SYNC = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         vin,
    output frame_marks_t marks
);

    localparam int SW = cnt_width(BLK_LEN);
    localparam int BW = cnt_width(BLKS_PER_SYNC);

    logic samp_first;
    logic samp_last;
    logic blk_first;

    // Sample position inside the current block
    generate
        if (BLK_LEN == 1) begin : g_samp_single
            assign samp_first = 1'b1;
            assign samp_last  = 1'b1;
        end else begin : g_samp_cnt
            logic [SW-1:0] samp_q;

            // Advance the sample index on every valid input, wrap at the block end
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    samp_q <= '0;
                end else if (vin) begin
                    samp_q <= (samp_q == SW'(BLK_LEN - 1)) ? '0 : samp_q + 1'b1;
                end
            end

            assign samp_first = (samp_q == '0);
            assign samp_last  = (samp_q == SW'(BLK_LEN - 1));
        end
    endgenerate

    // Block position inside the current sync group
    generate
        if (BLKS_PER_SYNC == 1) begin : g_blk_single
            assign blk_first = 1'b1;
        end else begin : g_blk_cnt
            logic [BW-1:0] blk_q;

            // Advance the block index when the last sample of a block is taken
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    blk_q <= '0;
                end else if (vin && samp_last) begin
                    blk_q <= (blk_q == BW'(BLKS_PER_SYNC - 1)) ? '0 : blk_q + 1'b1;
                end
            end

            assign blk_first = (blk_q == '0);
        end
    endgenerate

    // Register the markers so they align with the registered data path
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            marks <= '0;
        end else begin
            marks.valid <= vin;
            marks.sop   <= vin && samp_first;
            marks.eop   <= vin && samp_last;
            marks.sync  <= vin && samp_first && blk_first;
        end
    end

endmodule

// File: rtl/bsn_fifo.sv
// Module: bsn_fifo
// Small FIFO in registers with a show-ahead output: the oldest entry is on
// `head` whenever `empty` is low. A push while full is dropped unless a pop
// happens in the same cycle. A pop while empty is ignored.
// Assumes: DEPTH >= 2.
module bsn_fifo
    import reframer_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int W     = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        push,
    input  logic [W-1:0]                wdata,
    input  logic                        pop,
    output logic [W-1:0]                head,
    output logic                        empty,
    output logic [$clog2(DEPTH+1)-1:0]  level
);

    localparam int PW = cnt_width(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  store [DEPTH];
    logic [PW-1:0] wr_ptr;
    logic [PW-1:0] rd_ptr;
    logic [CW-1:0] count;
    logic          pop_ok;
    logic          push_ok;

    // Qualify the requests against the occupancy
    always_comb begin
        pop_ok  = pop && (count != '0);
        push_ok = push && ((count != CW'(DEPTH)) || pop_ok);
    end

    // Storage words; each is written only when the write pointer selects it
    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_word
            // Capture the pushed value into this slot
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    store[i] <= '0;
                end else if (push_ok && (wr_ptr == PW'(i))) begin
                    store[i] <= wdata;
                end
            end
        end
    endgenerate

    // Pointers and occupancy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) begin
                wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            end
            if (pop_ok) begin
                rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            end
            case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assign head  = store[rd_ptr];
    assign empty = (count == '0);
    assign level = count;

endmodule

// File: rtl/bsn_attach.sv
// Module: bsn_attach
// Places the restored sequence number on the output during a sync cycle and
// requests the pop. If the FIFO is empty at a sync, repeats the last value
// taken and sets a sticky underflow flag.
// Assumes: `sync` is a registered output marker, `head` is show-ahead.
module bsn_attach #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sync,
    input  logic         empty,
    input  logic [W-1:0] head,
    output logic         pop,
    output logic [W-1:0] bsn,
    output logic         underflow
);

    logic [W-1:0] held_q;

    // Select the value presented on the output field
    always_comb begin
        pop = sync;
        if (!sync) begin
            bsn = '0;
        end else if (empty) begin
            bsn = held_q;
        end else begin
            bsn = head;
        end
    end

    // Remember the last value taken and record an empty-queue sync
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q    <= '0;
            underflow <= 1'b0;
        end else if (sync) begin
            if (empty) begin
                underflow <= 1'b1;
            end else begin
                held_q <= head;
            end
        end
    end

endmodule

// File: rtl/stream_reframer.sv
// Module: stream_reframer (top)
// Rebuilds sop/eop/sync framing on a returning stream of valid samples and
// restores, on each output sync, the sequence number captured at an input
// sync. Data and valid pass through one register stage.
// Assumes: no backpressure; input and output syncs pair up in order.
module stream_reframer
    import reframer_pkg::*;
#(
    parameter int DATA_W        = 32,
    parameter int BSN_W         = 48,
    parameter int BLK_LEN       = 8,
    parameter int BLKS_PER_SYNC = 4,
    parameter int FIFO_DEPTH    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_sync,
    input  logic [BSN_W-1:0]  in_bsn,
    input  logic              ret_valid,
    input  logic [DATA_W-1:0] ret_data,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              out_sop,
    output logic              out_eop,
    output logic              out_sync,
    output logic [BSN_W-1:0]  out_bsn,
    output logic              bsn_underflow
);

    localparam int LW = $clog2(FIFO_DEPTH + 1);

    frame_marks_t      marks;
    logic [BSN_W-1:0]  fifo_head;
    logic              fifo_empty;
    logic              fifo_pop;
    logic [LW-1:0]     fifo_level;
    logic [DATA_W-1:0] data_q;

    frame_counter #(
        .BLK_LEN       (BLK_LEN),
        .BLKS_PER_SYNC (BLKS_PER_SYNC)
    ) u_count (
        .clk   (clk),
        .rst_n (rst_n),
        .vin   (ret_valid),
        .marks (marks)
    );

    bsn_fifo #(
        .DEPTH (FIFO_DEPTH),
        .W     (BSN_W)
    ) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (in_sync),
        .wdata (in_bsn),
        .pop   (fifo_pop),
        .head  (fifo_head),
        .empty (fifo_empty),
        .level (fifo_level)
    );

    bsn_attach #(
        .W (BSN_W)
    ) u_attach (
        .clk       (clk),
        .rst_n     (rst_n),
        .sync      (marks.sync),
        .empty     (fifo_empty),
        .head      (fifo_head),
        .pop       (fifo_pop),
        .bsn       (out_bsn),
        .underflow (bsn_underflow)
    );

    // One-stage data pipeline aligned with the registered markers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
        end else begin
            data_q <= ret_data;
        end
    end

    assign out_valid = marks.valid;
    assign out_data  = data_q;
    assign out_sop   = marks.sop;
    assign out_eop   = marks.eop;
    assign out_sync  = marks.sync;

endmodule

// File: rtl/stream_reframer_chk.sv
// Module: stream_reframer_chk
// Property checker bound to stream_reframer. Watches the ports and the
// queue occupancy.
module stream_reframer_chk #(
    parameter int BSN_W      = 48,
    parameter int FIFO_DEPTH = 16,
    parameter int LW         = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ret_valid,
    input logic             out_valid,
    input logic             out_sop,
    input logic             out_eop,
    input logic             out_sync,
    input logic [BSN_W-1:0] out_bsn,
    input logic             bsn_underflow,
    input logic [LW-1:0]    fifo_level
);

    // R1
    valid_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (out_valid == $past(ret_valid)));

    // R2
    sop_on_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_sop |-> out_valid);

    // R3
    eop_on_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_eop |-> out_valid);

    // R4
    sync_with_sop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_sync |-> out_sop);

    // R5
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_level <= LW'(FIFO_DEPTH));

    // R7
    bsn_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_sync |-> (out_bsn == '0));

    // R8
    underflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bsn_underflow |=> bsn_underflow);

endmodule

bind stream_reframer stream_reframer_chk #(
    .BSN_W      (BSN_W),
    .FIFO_DEPTH (FIFO_DEPTH),
    .LW         ($clog2(FIFO_DEPTH + 1))
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .ret_valid     (ret_valid),
    .out_valid     (out_valid),
    .out_sop       (out_sop),
    .out_eop       (out_eop),
    .out_sync      (out_sync),
    .out_bsn       (out_bsn),
    .bsn_underflow (bsn_underflow),
    .fifo_level    (fifo_level)
);

// File: tb/tb_stream_reframer.sv
module tb_stream_reframer;

    localparam int DATA_W = 16;
    localparam int BSN_W  = 32;
    localparam int LEN    = 5;
    localparam int NBLK   = 3;
    localparam int DEPTH  = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_sync = 1'b0;
    logic [BSN_W-1:0]  in_bsn = '0;
    logic              ret_valid = 1'b0;
    logic [DATA_W-1:0] ret_data = '0;
    logic              out_valid;
    logic [DATA_W-1:0] out_data;
    logic              out_sop;
    logic              out_eop;
    logic              out_sync;
    logic [BSN_W-1:0]  out_bsn;
    logic              bsn_underflow;

    int vectors = 0;
    int fails   = 0;

    always #2 clk = ~clk;

    stream_reframer #(
        .DATA_W        (DATA_W),
        .BSN_W         (BSN_W),
        .BLK_LEN       (LEN),
        .BLKS_PER_SYNC (NBLK),
        .FIFO_DEPTH    (DEPTH)
    ) dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .in_sync       (in_sync),
        .in_bsn        (in_bsn),
        .ret_valid     (ret_valid),
        .ret_data      (ret_data),
        .out_valid     (out_valid),
        .out_data      (out_data),
        .out_sop       (out_sop),
        .out_eop       (out_eop),
        .out_sync      (out_sync),
        .out_bsn       (out_bsn),
        .bsn_underflow (bsn_underflow)
    );

    // Behavioural reference state
    logic [BSN_W-1:0]  q[$];
    logic [BSN_W-1:0]  m_held = '0;
    logic              m_uf = 1'b0;
    int                m_samp = 0;
    int                m_blk = 0;
    logic              e_valid = 1'b0;
    logic [DATA_W-1:0] e_data = '0;
    logic              e_sop = 1'b0;
    logic              e_eop = 1'b0;
    logic              e_sync = 1'b0;
    logic              in_reset = 1'b1;

    // Reference model: advance one clock
    always @(posedge clk) begin
        if (!rst_n) begin
            q.delete();
            m_held = '0; m_uf = 1'b0; m_samp = 0; m_blk = 0;
            e_valid = 1'b0; e_data = '0; e_sop = 1'b0; e_eop = 1'b0; e_sync = 1'b0;
            in_reset = 1'b1;
        end else begin
            in_reset = 1'b0;
            if (e_sync) begin
                if (q.size() > 0) m_held = q.pop_front();
                else m_uf = 1'b1;
            end
            if (in_sync && q.size() < DEPTH) q.push_back(in_bsn);
            e_valid = ret_valid;
            e_data  = ret_data;
            e_sop   = ret_valid && (m_samp == 0);
            e_eop   = ret_valid && (m_samp == LEN - 1);
            e_sync  = e_sop && (m_blk == 0);
            if (ret_valid) begin
                m_samp++;
                if (m_samp == LEN) begin
                    m_samp = 0;
                    m_blk = (m_blk + 1) % NBLK;
                end
            end
        end
    end

    task automatic check_bit(input string tag, input logic act, input logic exp);
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare all outputs against the model, away from the clock edge
    task automatic compare();
        logic [BSN_W-1:0] eb;
        string rs;
        vectors++;
        eb = '0;
        if (e_sync) eb = (q.size() > 0) ? q[0] : m_held;
        rs = in_reset ? "R9 " : "";
        check_bit({rs, "R1 valid"}, out_valid, e_valid);
        check_bit({rs, "R2 sop"}, out_sop, e_sop);
        check_bit({rs, "R3 eop"}, out_eop, e_eop);
        check_bit({rs, "R4 sync"}, out_sync, e_sync);
        check_bit({rs, "R8 underflow"}, bsn_underflow, m_uf);
        if (out_data !== e_data) begin
            fails++;
            $display("FAIL %sR1 data: actual %0h expected %0h at %0t", rs, out_data, e_data, $time);
        end
        if (out_bsn !== eb) begin
            fails++;
            if (!e_sync)
                $display("FAIL %sR7 bsn: actual %0h expected %0h at %0t", rs, out_bsn, eb, $time);
            else if (q.size() == 0)
                $display("FAIL R8 bsn held: actual %0h expected %0h at %0t", out_bsn, eb, $time);
            else
                $display("FAIL R5/R6 bsn: actual %0h expected %0h at %0t", out_bsn, eb, $time);
        end
    endtask

    int bsn_ctr = 100;

    // One cycle: compare, then drive the next inputs
    task automatic step(input logic v, input logic s);
        @(negedge clk);
        compare();
        ret_valid = v;
        ret_data  = DATA_W'($urandom);
        in_sync   = s;
        if (s) begin
            bsn_ctr++;
            in_bsn = BSN_W'(bsn_ctr);
        end else begin
            in_bsn = BSN_W'($urandom);
        end
    endtask

    initial begin
        // R9: reset state
        repeat (3) step(1'b1, 1'b1);
        @(negedge clk); compare(); rst_n = 1'b1;
        // R2 R4 R6: continuous valid, syncs at the group rate
        for (int i = 0; i < 600; i++) step(1'b1, (i % (LEN * NBLK)) == 0);
        // R2 R3: gapped valid with sparse random syncs
        for (int i = 0; i < 800; i++) step(($urandom % 10) < 6, ($urandom % 20) == 0);
        // R8: drain the queue until output syncs find it empty
        for (int i = 0; i < 400; i++) step(1'b1, 1'b0);
        // R9: reset in mid-stream
        @(negedge clk); compare(); rst_n = 1'b0;
        step(1'b1, 1'b1);
        @(negedge clk); compare(); rst_n = 1'b1;
        // R5: overfill the queue with no output, then read it out
        for (int i = 0; i < 20; i++) step(1'b0, 1'b1);
        for (int i = 0; i < 400; i++) step(1'b1, 1'b0);
        // R6: stores and removals in the same cycle
        for (int i = 0; i < 300; i++) step(1'b1, 1'b1);
        step(1'b0, 1'b0);
        @(negedge clk); compare();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    // Watchdog
    initial begin
        #200000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule